// File: doc/BRIEF.md
# Burst Column Order Generator

This block turns a read or write command into the column address sequence of one memory data burst, one beat per clock. A command brings a three-bit starting column and a direction. A small mode register, loaded through its own write strobe, holds the burst length (four or eight beats) and the ordering (linear wrap or XOR). For every beat the block presents the low three column bits and marks the final beat. A new command issued during the final beat starts the next burst on the following cycle, so bursts can run back to back without a gap.

The block also polices the burst rules. A four-beat burst cannot be cut short. An eight-beat burst may be cut short only by a command of the same direction, and only at its half-way point. There is no stop command. Any command or mode write that breaks these rules is dropped and sets a sticky error flag. The flag stays set until reset.

Beats are produced at a fixed one-per-cycle rate and the consumer cannot stall them, so the beat output has no ready signal. The command input has no ready signal either. A command offered in a cycle is either taken on that edge or rejected and flagged. It is never held back.

Top module: `burst_col_seq`

## Requirements
- R1: After synchronous active-high reset, beat_valid, last_beat and illegal_cmd are 0, and the mode is four-beat linear.
- R2: A mode write loads mode_data as follows. Bits [2:0] are the length code: 3'b010 selects four beats and 3'b011 selects eight beats. Bit 3 is the ordering: 0 selects linear and 1 selects XOR. A write with any other length code is dropped, leaving the mode unchanged, and it sets illegal_cmd.
- R3: An accepted command gives its first beat on the next cycle, with beat_col equal to start_col. The burst then gives one beat per cycle for exactly its length, and last_beat is high only on the final beat.
- R4: In four-beat linear mode, beat i carries bit 2 of start_col unchanged, and its low two bits are (start_col[1:0] + i) mod 4.
- R5: In eight-beat linear mode, the low two bits count up mod 4 from the start value. Bit 2 equals start bit 2 for beats 0 to 3 and is inverted for beats 4 to 7. For example, start 5 gives 5,6,7,4,1,2,3,0.
- R6: In XOR mode, beat i is start_col XOR i. For four-beat bursts i < 4, so bit 2 is held.
- R7: A command offered while no burst runs, or during a final beat, is accepted, and its burst follows with no idle cycle.
- R8: A command offered during a non-final beat of a four-beat burst is dropped and sets illegal_cmd.
- R9: In an eight-beat burst, a command of the same direction offered during beat 3 is accepted. Its first beat appears on the next cycle and the old burst is abandoned.
- R10: In an eight-beat burst, a command of the other direction, or one offered during any non-final beat other than beat 3, is dropped and sets illegal_cmd.
- R11: A mode write during a non-final beat is dropped and sets illegal_cmd, and the mode is unchanged.
- R12: illegal_cmd stays at 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_is_write | input | 1 | 1 = write command, 0 = read command |
| start_col | input | 3 | Starting column (low three bits) |
| mode_wr | input | 1 | Mode register write strobe |
| mode_data | input | 4 | [2:0] length code, [3] ordering |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_col | output | 3 | Column bits for the current beat |
| last_beat | output | 1 | Current beat is the final one of its burst |
| illegal_cmd | output | 1 | Sticky error flag for dropped commands and mode writes |

## Verification
The ordering logic is driven with starts that have bit 2 both clear and set, in both lengths and both orderings. This separates the linear wrap inside a nibble from a plain count, and a held bit 2 from an inverted one. Bursts are chained in the final-beat cycle and at the half-way point. These cases show whether a gap or a stale beat appears when one burst follows another. Commands of the wrong direction, at the wrong beat, or during a four-beat burst are offered alongside mid-burst and bad-code mode writes. Each of these must leave the beat stream untouched and raise only the flag, and the orders of later bursts show that the mode did not change.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int COL_W    = 3;
  localparam int LEN_W    = 3;
  localparam int TYPE_BIT = LEN_W;
  localparam int MODE_W   = LEN_W + 1;
  localparam int NIB_BEATS = 4;

  typedef enum logic {ORD_LIN = 1'b0, ORD_XOR = 1'b1} order_e;

  typedef struct packed {
    logic   bl8;
    order_e order;
  } mode_t;

  typedef struct packed {
    logic [COL_W-1:0] start;
    logic             is_wr;
    mode_t            mode;
  } burst_t;
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
#(
  parameter logic [LEN_W-1:0] BL4_CODE = 3'b010,
  parameter logic [LEN_W-1:0] BL8_CODE = 3'b011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              allow,
  input  logic [MODE_W-1:0] data,
  output mode_t             mode,
  output logic              reject
);
  logic [LEN_W-1:0] len;
  logic             len_ok;
  logic             take;

  assign len    = data[LEN_W-1:0];
  assign len_ok = (len == BL4_CODE) || (len == BL8_CODE);
  assign take   = wr_en && allow && len_ok;
  assign reject = wr_en && !take;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode.bl8   <= 1'b0;
      mode.order <= ORD_LIN;
    end else if (take) begin
      mode.bl8   <= (len == BL8_CODE);
      mode.order <= order_e'(data[TYPE_BIT]);
    end
  end
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_is_write,
  input  logic [COL_W-1:0] start_col,
  input  mode_t            mode,
  output logic             busy,
  output logic [COL_W-1:0] cnt,
  output burst_t           cur,
  output logic             last,
  output logic             open_slot,
  output logic             cmd_reject
);
  localparam logic [COL_W-1:0] END4    = COL_W'(NIB_BEATS - 1);
  localparam logic [COL_W-1:0] END8    = COL_W'(2 * NIB_BEATS - 1);
  localparam logic [COL_W-1:0] NIB_END = COL_W'(NIB_BEATS - 1);

  logic half_point;
  logic cmd_ok;

  assign last       = busy && (cnt == (cur.mode.bl8 ? END8 : END4));
  assign open_slot  = !busy || last;
  assign half_point = busy && cur.mode.bl8 && (cnt == NIB_END);
  assign cmd_ok     = cmd_valid &&
                      (open_slot || (half_point && (cmd_is_write == cur.is_wr)));
  assign cmd_reject = cmd_valid && !cmd_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      cur  <= '0;
    end else if (cmd_ok) begin
      busy      <= 1'b1;
      cnt       <= '0;
      cur.start <= start_col;
      cur.is_wr <= cmd_is_write;
      cur.mode  <= mode;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
  import bcs_pkg::*;
(
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] idx,
  input  order_e           order,
  output logic [COL_W-1:0] col
);
  localparam int LOW_W = $clog2(NIB_BEATS);

  logic [COL_W-1:0] xor_col;
  logic [COL_W-1:0] lin_col;

  for (genvar b = 0; b < COL_W; b++) begin : g_xor
    assign xor_col[b] = start[b] ^ idx[b];
  end

  assign lin_col[LOW_W-1:0]     = start[LOW_W-1:0] + idx[LOW_W-1:0];
  assign lin_col[COL_W-1:LOW_W] = start[COL_W-1:LOW_W] ^ idx[COL_W-1:LOW_W];

  assign col = (order == ORD_XOR) ? xor_col : lin_col;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter logic [2:0] BL4_CODE = 3'b010,
  parameter logic [2:0] BL8_CODE = 3'b011
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic       cmd_is_write,
  input  logic [2:0] start_col,
  input  logic       mode_wr,
  input  logic [3:0] mode_data,
  output logic       beat_valid,
  output logic [2:0] beat_col,
  output logic       last_beat,
  output logic       illegal_cmd
);
  mode_t            mode_q;
  burst_t           cur;
  logic             busy;
  logic [COL_W-1:0] cnt;
  logic             last;
  logic             open_slot;
  logic             cmd_reject;
  logic             mode_reject;
  logic             illegal_q;
  logic             run_bl8;
  logic             run_wr;

  bcs_mode_reg #(.BL4_CODE(BL4_CODE), .BL8_CODE(BL8_CODE)) u_mode (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (mode_wr),
    .allow  (open_slot),
    .data   (mode_data),
    .mode   (mode_q),
    .reject (mode_reject)
  );

  bcs_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_is_write (cmd_is_write),
    .start_col    (start_col),
    .mode         (mode_q),
    .busy         (busy),
    .cnt          (cnt),
    .cur          (cur),
    .last         (last),
    .open_slot    (open_slot),
    .cmd_reject   (cmd_reject)
  );

  bcs_col_gen u_col (
    .start (cur.start),
    .idx   (cnt),
    .order (cur.mode.order),
    .col   (beat_col)
  );

  always_ff @(posedge clk) begin
    if (rst) illegal_q <= 1'b0;
    else     illegal_q <= illegal_q | cmd_reject | mode_reject;
  end

  assign beat_valid  = busy;
  assign last_beat   = last;
  assign illegal_cmd = illegal_q;
  assign run_bl8     = cur.mode.bl8;
  assign run_wr      = cur.is_wr;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_is_write,
  input logic [2:0] start_col,
  input logic       mode_wr,
  input logic       beat_valid,
  input logic [2:0] beat_col,
  input logic       last_beat,
  input logic       illegal_cmd,
  input logic       run_bl8,
  input logic       run_wr
);
  a_r3_last_needs_beat: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> beat_valid);

  a_r3_burst_ends: assert property (@(posedge clk) disable iff (rst)
    beat_valid && last_beat && !cmd_valid |=> !beat_valid);

  a_r7_open_start: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (!beat_valid || last_beat) |=> beat_valid && (beat_col == $past(start_col)));

  a_r8_bl4_no_cut: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && beat_valid && !last_beat && !run_bl8 |=> illegal_cmd);

  a_r10_mixed_cut: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && beat_valid && !last_beat && run_bl8 && (cmd_is_write != run_wr) |=> illegal_cmd);

  a_r11_mode_locked: assert property (@(posedge clk) disable iff (rst)
    mode_wr && beat_valid && !last_beat |=> illegal_cmd);

  a_r12_sticky: assert property (@(posedge clk) disable iff (rst)
    illegal_cmd |=> illegal_cmd);
endmodule

bind burst_col_seq burst_col_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_valid    (cmd_valid),
  .cmd_is_write (cmd_is_write),
  .start_col    (start_col),
  .mode_wr      (mode_wr),
  .beat_valid   (beat_valid),
  .beat_col     (beat_col),
  .last_beat    (last_beat),
  .illegal_cmd  (illegal_cmd),
  .run_bl8      (run_bl8),
  .run_wr       (run_wr)
);

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_is_write = 1'b0;
  logic [2:0] start_col = '0;
  logic       mode_wr = 1'b0;
  logic [3:0] mode_data = '0;
  logic       beat_valid;
  logic [2:0] beat_col;
  logic       last_beat;
  logic       illegal_cmd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit m_bl8 = 1'b0;
  bit m_xor = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  burst_col_seq u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_is_write(cmd_is_write),
    .start_col(start_col), .mode_wr(mode_wr), .mode_data(mode_data),
    .beat_valid(beat_valid), .beat_col(beat_col), .last_beat(last_beat),
    .illegal_cmd(illegal_cmd)
  );

  function automatic logic [2:0] want_col(int s, int i, bit use_xor);
    int c;
    if (use_xor) c = s ^ i;
    else c = ((s % 4 + i) % 4) + 4 * (((s / 4) + (i / 4)) % 2);
    return 3'(c);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected beats as the design presents them
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (last_beat && !beat_valid)
        check(1'b0, "R3", "last_beat without beat_valid", 1, 0);
      if (beat_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected beat col", int'(beat_col), -1);
        end else begin
          logic [3:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(beat_col == e[2:0], t, "beat_col", int'(beat_col), int'(e[2:0]));
          check(last_beat == e[3], t, "last_beat", int'(last_beat), int'(e[3]));
        end
      end
    end
  end

  task automatic drive_cmd(int s, bit wr, int npush, string tag);
    int bl;
    bl = m_bl8 ? 8 : 4;
    cmd_valid = 1'b1;
    cmd_is_write = wr;
    start_col = 3'(s);
    for (int i = 0; i < npush; i++) begin
      exp_q.push_back({(i == bl - 1), want_col(s, i, m_xor)});
      tag_q.push_back(tag);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic write_mode(logic [3:0] d, bit take);
    mode_wr = 1'b1;
    mode_data = d;
    if (take) begin
      m_bl8 = (d[2:0] == 3'b011);
      m_xor = d[3];
    end
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic drain(string tag);
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, tag, "beats left unseen", exp_q.size(), 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    m_bl8 = 1'b0;
    m_xor = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(beat_valid == 1'b0, "R1", "beat_valid", int'(beat_valid), 0);
    check(last_beat == 1'b0, "R1", "last_beat", int'(last_beat), 0);
    check(illegal_cmd == 1'b0, "R1", "illegal_cmd", int'(illegal_cmd), 0);

    // R1/R4: default mode is four-beat linear; A2 held
    drive_cmd(1, 0, 4, "R4");
    drain("R4");
    drive_cmd(6, 1, 4, "R4");
    drain("R4");

    // R6 four-beat XOR
    write_mode(4'b1010, 1'b1);
    drive_cmd(3, 0, 4, "R6");
    drain("R6");
    drive_cmd(5, 1, 4, "R6");
    drain("R6");

    // R5 eight-beat linear
    write_mode(4'b0011, 1'b1);
    drive_cmd(5, 0, 8, "R5");
    drain("R5");
    drive_cmd(2, 1, 8, "R5");
    drain("R5");

    // R6 eight-beat XOR
    write_mode(4'b1011, 1'b1);
    drive_cmd(6, 0, 8, "R6");
    drain("R6");

    // R7 seamless: next command in the final-beat cycle
    write_mode(4'b0011, 1'b1);
    drive_cmd(0, 0, 8, "R7");
    repeat (7) @(negedge clk);
    check(last_beat == 1'b1, "R7", "last_beat before chain", int'(last_beat), 1);
    drive_cmd(3, 0, 8, "R7");
    check(beat_valid == 1'b1, "R7", "no gap beat_valid", int'(beat_valid), 1);
    check(beat_col == 3'd3, "R7", "first chained col", int'(beat_col), 3);
    drain("R7");

    // R9 legal same-direction cut at beat 3
    drive_cmd(2, 0, 4, "R9");
    repeat (3) @(negedge clk);
    drive_cmd(7, 0, 8, "R9");
    check(beat_col == 3'd7, "R9", "first col after cut", int'(beat_col), 7);
    drain("R9");
    check(illegal_cmd == 1'b0, "R9", "illegal_cmd after legal cut", int'(illegal_cmd), 0);

    // R10 mixed direction at beat 3 is dropped
    drive_cmd(1, 0, 8, "R10");
    repeat (3) @(negedge clk);
    drive_cmd(4, 1, 0, "R10");
    drain("R10");
    check(illegal_cmd == 1'b1, "R10", "illegal_cmd mixed cut", int'(illegal_cmd), 1);
    do_reset();
    check(illegal_cmd == 1'b0, "R1", "illegal_cmd after reset", int'(illegal_cmd), 0);

    // R10 same direction off the half-way point is dropped
    write_mode(4'b0011, 1'b1);
    drive_cmd(1, 1, 8, "R10");
    repeat (1) @(negedge clk);
    drive_cmd(6, 1, 0, "R10");
    drain("R10");
    check(illegal_cmd == 1'b1, "R10", "illegal_cmd off-point cut", int'(illegal_cmd), 1);
    do_reset();

    // R8 four-beat burst may not be cut
    drive_cmd(0, 0, 4, "R8");
    repeat (1) @(negedge clk);
    drive_cmd(2, 0, 0, "R8");
    drain("R8");
    check(illegal_cmd == 1'b1, "R8", "illegal_cmd four-beat cut", int'(illegal_cmd), 1);
    do_reset();

    // R11 mode write mid-burst dropped; mode stays four-beat linear
    drive_cmd(0, 0, 4, "R11");
    repeat (1) @(negedge clk);
    write_mode(4'b1011, 1'b0);
    drain("R11");
    check(illegal_cmd == 1'b1, "R11", "illegal_cmd mid-burst mode write", int'(illegal_cmd), 1);
    drive_cmd(5, 0, 4, "R11");
    drain("R11");
    // R12 flag holds through later legal traffic
    check(illegal_cmd == 1'b1, "R12", "illegal_cmd sticky", int'(illegal_cmd), 1);
    do_reset();

    // R2 bad length code dropped; mode unchanged
    write_mode(4'b1001, 1'b0);
    @(negedge clk);
    check(illegal_cmd == 1'b1, "R2", "illegal_cmd bad length code", int'(illegal_cmd), 1);
    drive_cmd(6, 0, 4, "R2");
    drain("R2");
    do_reset();

    finish_up();
  end
endmodule